// File: doc/BRIEF.md
# Decrementer Timer with 64-bit Time Base

This unit gives a processor two timing resources. The first is a free-running time base made of two data words. The second is a down-counting decrementer that asks for a timer interrupt when it runs out. Software reads and writes every register through a single select-addressed port. The time base advances on each cycle in which the `tick` strobe is high, whatever the decrementer is doing.

The decrementer moves only while three conditions hold together: the enable bit in the control register is set, the processor's external-interrupt enable input is high, and the interrupt-pending bit in the status register is clear. The count stops at zero and is never reloaded by the hardware. To start a new interval, software writes a fresh value, then clears the pending bit by writing a one to it.

Top module: `decr_timer`

## Requirements
- R1: On every cycle with `tick` high, the lower time-base word (select 0) increases by one. On cycles with `tick` low it holds its value.
- R2: On a tick where the lower word is all ones, the upper time-base word (select 1) increases by one, so the two words form a 64-bit count.
- R3: The decrementer (select 2) moves on a tick only when control bit 26 (select 3) is 1 and `ext_irq_en` is high. Otherwise it holds.
- R4: While status bit 27 (select 4) is 1, the decrementer holds and no new interrupt is raised.
- R5: The decrementer steps down by one only while it is above zero. At zero it stays at zero and never wraps.
- R6: On a counting tick where the decrementer is 1 or 0, the count leaves or stays at zero and status bit 27 is set in the same edge. `irq` is high exactly while status bit 27 is 1, and no value is reloaded.
- R7: Writing select 4 with data bit 27 = 1 clears the status bit. Writing it with bit 27 = 0 has no effect, and a new interrupt in the same edge wins over the clear.
- R8: A software write to the decrementer or to either time-base word takes priority over the count or increment in the same cycle. A write to the lower word also suppresses that cycle's carry into the upper word.
- R9: Selects 0 to 4 map to lower time base, upper time base, decrementer, control and status. The status word reads only bit 27, and selects 5 to 7 read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| tick | input | 1 | Time-base and decrementer advance strobe |
| ext_irq_en | input | 1 | Processor external-interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Register select for the combinational read |
| rd_data | output | 32 | Read data for `rd_sel` |
| irq | output | 1 | Timer interrupt request (status bit 27) |

## Verification
The hardest cases to reach from the ports are the one-cycle coincidences: a decrementer write landing on the same tick that would take the count from 1 to 0, and a status clear landing on the edge where a zero count would raise a new interrupt. The bench steers the count to those exact values with preloaded writes, then issues the colliding write in that cycle. The upper-word carry would need 2^32 ticks, so the lower word is preloaded just under all ones and ticked across the boundary, including once with a simultaneous lower-word write. A long stretch of random ticks, enables, writes and clears then runs against a behavioural model, which compares every register in turn on every cycle.

// File: rtl/timer_pkg.sv
package timer_pkg;
   localparam int SEL_W = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_TBL = 3'd0,
      SEL_TBU = 3'd1,
      SEL_DEC = 3'd2,
      SEL_CTL = 3'd3,
      SEL_STS = 3'd4
   } reg_sel_e;
endpackage

// File: rtl/tmr_timebase.sv
module tmr_timebase #(
   parameter int DATA_W   = 32,
   parameter bit UPPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] lo_q,
   output logic [DATA_W-1:0] hi_q
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic carry;
   assign carry = tick & ~wr_lo & (&lo_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lo_q <= '0;
      else if (wr_lo)  lo_q <= wdata;
      else if (tick)   lo_q <= lo_q + ONE;
   end

   generate
      if (UPPER_EN) begin : g_upper
         logic [DATA_W-1:0] hi_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      hi_r <= '0;
            else if (wr_hi)  hi_r <= wdata;
            else if (carry)  hi_r <= hi_r + ONE;
         end
         assign hi_q = hi_r;

         // R2
         hi_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tick && !wr_lo && !wr_hi && (&lo_q)) |=> (hi_q == $past(hi_q) + ONE));
      end else begin : g_no_upper
         logic unused_hi;
         assign unused_hi = wr_hi ^ carry;
         assign hi_q = '0;
      end
   endgenerate

   // R1
   lo_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wr_lo) |=> (lo_q == $past(lo_q) + ONE));

   // R1
   lo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !wr_lo) |=> $stable(lo_q));
endmodule

// File: rtl/tmr_decrementer.sv
module tmr_decrementer #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              load,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dec_q,
   output logic              near_zero
);
   localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

   logic at_zero;
   assign at_zero   = (dec_q == '0);
   assign near_zero = at_zero | (dec_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 dec_q <= '0;
      else if (load)              dec_q <= wdata;
      else if (step && !at_zero)  dec_q <= dec_q - ONE;
   end

   // R5
   dec_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_q == '0 && !load) |=> (dec_q == '0));

   // R8
   dec_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (dec_q == $past(wdata)));
endmodule

// File: rtl/tmr_status.sv
module tmr_status (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   output logic pend_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     pend_q <= 1'b0;
      else if (set)   pend_q <= 1'b1;
      else if (clr)   pend_q <= 1'b0;
   end

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set |=> pend_q);
endmodule

// File: rtl/decr_timer.sv
module decr_timer
   import timer_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IE_BIT      = 26,
   parameter int ST_BIT      = 27,
   parameter bit TB_UPPER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              ext_irq_en,
   input  logic              wr_en,
   input  logic [SEL_W-1:0]  wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic              irq
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("decr_timer: DATA_W must be at least 2");
      end
      if (IE_BIT < 0 || IE_BIT >= DATA_W) begin : g_bad_ie
         $error("decr_timer: IE_BIT outside the data word");
      end
      if (ST_BIT < 0 || ST_BIT >= DATA_W) begin : g_bad_st
         $error("decr_timer: ST_BIT outside the data word");
      end
   endgenerate

   logic wr_tbl, wr_tbu, wr_dec, wr_ctl, wr_sts;
   assign wr_tbl = wr_en && (wr_sel == SEL_TBL);
   assign wr_tbu = wr_en && (wr_sel == SEL_TBU);
   assign wr_dec = wr_en && (wr_sel == SEL_DEC);
   assign wr_ctl = wr_en && (wr_sel == SEL_CTL);
   assign wr_sts = wr_en && (wr_sel == SEL_STS);

   logic [DATA_W-1:0] ctl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (wr_ctl) ctl_q <= wr_data;
   end

   logic [DATA_W-1:0] tb_lo, tb_hi, dec_val;
   logic              pend, near_zero, gate_open, step, raise, clear;

   assign gate_open = ctl_q[IE_BIT] & ext_irq_en & ~pend;
   assign step      = tick & gate_open;
   assign raise     = step & ~wr_dec & near_zero;
   assign clear     = wr_sts & wr_data[ST_BIT];

   tmr_timebase #(.DATA_W(DATA_W), .UPPER_EN(TB_UPPER_EN)) u_tb (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .wr_lo (wr_tbl),
      .wr_hi (wr_tbu),
      .wdata (wr_data),
      .lo_q  (tb_lo),
      .hi_q  (tb_hi)
   );

   tmr_decrementer #(.DATA_W(DATA_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .load      (wr_dec),
      .wdata     (wr_data),
      .dec_q     (dec_val),
      .near_zero (near_zero)
   );

   tmr_status u_sts (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (raise),
      .clr    (clear),
      .pend_q (pend)
   );

   logic [DATA_W-1:0] sts_word;
   always_comb begin
      sts_word         = '0;
      sts_word[ST_BIT] = pend;
   end

   always_comb begin
      case (rd_sel)
         SEL_TBL: rd_data = tb_lo;
         SEL_TBU: rd_data = tb_hi;
         SEL_DEC: rd_data = dec_val;
         SEL_CTL: rd_data = ctl_q;
         SEL_STS: rd_data = sts_word;
         default: rd_data = '0;
      endcase
   end

   assign irq = pend;

   // R3
   gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(ctl_q[IE_BIT] && ext_irq_en) && !wr_dec) |=> $stable(dec_val));

   // R4
   pend_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !wr_dec) |=> $stable(dec_val));

   // R6
   irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && ctl_q[IE_BIT] && ext_irq_en && !irq && !wr_dec && dec_val == DATA_W'(1))
      |=> (dec_val == '0 && irq));

   // R7
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && wr_sts && wr_data[ST_BIT]) |=> !irq);
endmodule

// File: tb/decr_timer_tb.sv
module decr_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        ext_irq_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_sel = 3'd0;
   logic [31:0] wr_data = 32'd0;
   logic [2:0]  rd_sel = 3'd0;
   logic [31:0] rd_data;
   logic        irq;

   always #4 clk = ~clk;

   decr_timer u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .ext_irq_en(ext_irq_en),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
   );

   // behavioural reference model
   logic [63:0] m_tb;
   logic [31:0] m_dec, m_ctl;
   bit          m_pend;
   int          n_cmp = 0, n_bad = 0, ncyc = 0;
   bit          done = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_tb = 64'd0; m_dec = 32'd0; m_ctl = 32'd0; m_pend = 1'b0;
      end else begin
         bit counting, w_dec, fire;
         logic [63:0] ntb;
         counting = tick && m_ctl[26] && ext_irq_en && !m_pend;
         w_dec    = wr_en && wr_sel == 3'd2;
         fire     = counting && !w_dec && (m_dec <= 32'd1);
         ntb = tick ? m_tb + 64'd1 : m_tb;
         if (wr_en && wr_sel == 3'd0) ntb = {m_tb[63:32], wr_data};
         if (wr_en && wr_sel == 3'd1) ntb[63:32] = wr_data;
         m_tb = ntb;
         if (w_dec) m_dec = wr_data;
         else if (counting && m_dec != 0) m_dec = m_dec - 32'd1;
         if (wr_en && wr_sel == 3'd3) m_ctl = wr_data;
         if (fire) m_pend = 1'b1;
         else if (wr_en && wr_sel == 3'd4 && wr_data[27]) m_pend = 1'b0;
      end
   end

   function automatic logic [31:0] expect_rd(input logic [2:0] s);
      case (s)
         3'd0: return m_tb[31:0];
         3'd1: return m_tb[63:32];
         3'd2: return m_dec;
         3'd3: return m_ctl;
         3'd4: return {4'd0, m_pend, 27'd0};
         default: return 32'd0;
      endcase
   endfunction

   function automatic string tag_of(input logic [2:0] s);
      case (s)
         3'd0: return "R1 time base low";
         3'd1: return "R2 time base high";
         3'd2: return "R3/R4/R5/R8 decrementer";
         3'd3: return "R9 control";
         3'd4: return "R6/R7 status";
         default: return "R9 unused select";
      endcase
   endfunction

   task automatic compare();
      logic [31:0] e;
      e = expect_rd(rd_sel);
      n_cmp++;
      if (rd_data !== e) begin
         n_bad++;
         $display("FAIL %s: sel %0d actual %h expected %h", tag_of(rd_sel), rd_sel, rd_data, e);
      end
      n_cmp++;
      if (irq !== m_pend) begin
         n_bad++;
         $display("FAIL R6 irq: actual %b expected %b", irq, m_pend);
      end
   endtask

   task automatic cyc(input logic t, input logic e, input logic we,
                      input logic [2:0] ws, input logic [31:0] wd);
      @(negedge clk);
      compare();
      tick = t; ext_irq_en = e; wr_en = we; wr_sel = ws; wr_data = wd;
      rd_sel = 3'(ncyc % 6);
      ncyc++;
   endtask

   task automatic run(input int n, input logic t, input logic e);
      for (int i = 0; i < n; i++) cyc(t, e, 1'b0, 3'd0, 32'd0);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      // reset state, all registers zero (R9)
      run(3, 1'b0, 1'b0);
      rst_n = 1'b1;
      run(6, 1'b0, 1'b0);
      // R1: time base ticks with decrementer idle, holds without tick
      run(7, 1'b1, 1'b0);
      run(6, 1'b0, 1'b1);
      // R3: enable bit set, external enable low -> holds
      cyc(1'b1, 1'b0, 1'b1, 3'd3, 32'h0400_0000);
      cyc(1'b1, 1'b0, 1'b1, 3'd2, 32'd5);
      run(6, 1'b1, 1'b0);
      // R6: count 5 down to zero and raise
      run(8, 1'b1, 1'b1);
      // R4: frozen while pending, even with a fresh value
      cyc(1'b1, 1'b1, 1'b1, 3'd2, 32'd9);
      run(6, 1'b1, 1'b1);
      // R7: bit-0-only write does not clear
      cyc(1'b1, 1'b1, 1'b1, 3'd4, 32'h0000_0001);
      run(6, 1'b1, 1'b1);
      // R7: clear, then count resumes from 9
      cyc(1'b1, 1'b1, 1'b1, 3'd4, 32'h0800_0000);
      run(12, 1'b1, 1'b1);
      // R5: at zero, clear -> re-raised, no wrap, no reload
      cyc(1'b1, 1'b1, 1'b1, 3'd4, 32'hFFFF_FFFF);
      run(6, 1'b1, 1'b1);
      // R8: write collides with the 1 -> 0 step
      cyc(1'b0, 1'b1, 1'b1, 3'd2, 32'd2);
      cyc(1'b0, 1'b1, 1'b1, 3'd4, 32'h0800_0000);
      cyc(1'b1, 1'b1, 1'b0, 3'd0, 32'd0);
      cyc(1'b1, 1'b1, 1'b1, 3'd2, 32'd3);
      run(6, 1'b1, 1'b1);
      // R3: control bit cleared
      cyc(1'b0, 1'b1, 1'b1, 3'd4, 32'h0800_0000);
      cyc(1'b0, 1'b1, 1'b1, 3'd2, 32'd20);
      cyc(1'b1, 1'b1, 1'b1, 3'd3, 32'hFBFF_FFFF);
      run(6, 1'b1, 1'b1);
      // R2: carry into upper word
      cyc(1'b1, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFC);
      run(8, 1'b1, 1'b1);
      cyc(1'b1, 1'b1, 1'b1, 3'd1, 32'h0000_0007);
      // R8: lower write at the all-ones boundary suppresses carry
      cyc(1'b1, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF);
      cyc(1'b1, 1'b1, 1'b1, 3'd0, 32'h0000_0100);
      run(6, 1'b1, 1'b1);
      // R8: upper write during a carry wins
      cyc(1'b1, 1'b1, 1'b1, 3'd0, 32'hFFFF_FFFF);
      cyc(1'b1, 1'b1, 1'b1, 3'd1, 32'h0000_00AA);
      run(6, 1'b1, 1'b1);
      // R9: unused selects ignore writes and read zero
      cyc(1'b0, 1'b1, 1'b1, 3'd5, 32'hDEAD_BEEF);
      cyc(1'b0, 1'b1, 1'b1, 3'd6, 32'h1234_5678);
      cyc(1'b0, 1'b1, 1'b1, 3'd7, 32'hFFFF_FFFF);
      run(12, 1'b0, 1'b1);
      // mixed random traffic against the model (R1-R9)
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] r;
         logic [2:0]  s;
         logic [31:0] d;
         r = $urandom;
         s = 3'($urandom % 8);
         case (s)
            3'd2: d = 32'($urandom % 6);
            3'd3: d = (r[3:0] != 0) ? 32'h0400_0000 : 32'd0;
            3'd4: d = r[4] ? 32'h0800_0000 : 32'h0000_0010;
            3'd0: d = r[5] ? 32'hFFFF_FFFE : $urandom;
            default: d = $urandom;
         endcase
         cyc(r[8] | r[9], r[10] | r[11] | r[12], (r[15:13] == 3'd0), s, d);
      end
      run(4, 1'b0, 1'b0);
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule